// File: doc/BRIEF.md
# Move and ALU pair fusion unit

This unit sits in a decode pipeline after pre-decode. It watches a stream of instruction descriptors and joins a plain register-to-register move with the ALU operation right behind it into a single fused beat, so that later stages handle one slot instead of two. A descriptor names a class, the opcode byte, a destination register, up to two register sources with their own valid bits, and flags for an immediate and a memory operand.

A move that could start a pair is parked in a one-entry buffer until the next instruction shows up. If that instruction meets every dependency rule, one beat leaves carrying both descriptors and the fused flag. If not, the parked move leaves alone, and the newcomer is then looked at afresh. It may pass straight through, or it may be parked as the next candidate. Both sides use valid/ready handshakes. A flush input discards the parked move.

Top module: `movalu_fuse`

## Requirements
- R1: A descriptor is a parked candidate only if its class is MOV (code 1), its opcode byte is 0x89 or 0x8B, its first source is valid, and it has neither an immediate nor a memory operand. The descriptor layout, LSB first, is: class (4 bits), opcode (8), destination (RW), source0 (RW), source1 (RW), source0 valid, source1 valid, immediate flag, memory flag. A parked candidate is never emitted while no further instruction arrives.
- R2: Only the ALU class codes 2 to 14 can be the second half of a pair. These are ADD=2, ADC=3, AND=4, OR=5, XOR=6, SUB=7, SBB=8, INC=9, DEC=10, NOT=11, SHL/SAL=12, SHR=13, SAR=14. Codes 0 and 15 and MOV never fuse.
- R3: Fusion requires the ALU destination to equal the move destination.
- R4: An ALU descriptor with its memory flag set never fuses.
- R5: Fusion requires at least one valid ALU source to equal the move's source or the move's destination.
- R6: An ALU descriptor with both sources valid and equal never fuses.
- R7: Only an older move pairs with a younger ALU op. If the follower does not qualify, the move is emitted alone first, and the follower is then treated as a fresh input (passed through, or parked if it is itself a candidate).
- R8: A pair leaves as exactly one beat with out_fused=1, out_first holding the move and out_second holding the ALU descriptor. Every unfused beat has out_second equal to zero.
- R9: While flush is high, the parked move is dropped without being emitted and no input is accepted.
- R10: While out_valid is high and out_ready is low, the output beat holds steady. Every instruction appears exactly once, in order, under any backpressure.
- R11: After reset, out_valid is low and nothing is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop the parked move and refuse input |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Input descriptor accepted this cycle |
| in_desc | input | 16+3*RW | Input descriptor |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_fused | output | 1 | Beat carries a fused pair |
| out_first | output | 16+3*RW | Move of a pair, or the lone instruction |
| out_second | output | 16+3*RW | ALU op of a pair, zero otherwise |

## Verification
A vector table pairs one move with one follower. Each follower breaks exactly one rule: destination mismatch, memory operand, unrelated sources, twin sources, or a non-fusible class. Other followers pass through the source-read path or the destination-read path, or use an immediate-only shift. This separates every blocking condition from the fusing ones. Directed runs put a move behind an ALU op, put a move behind a move, use an opcode byte outside the two allowed, park a move with no follower, and flush a parked move. These show the ordering rule, the spill-then-retry path and discard without emission. A long random stream under random output stalls, checked beat by beat against a queue model, exposes any lost, repeated or reordered instruction.

// File: rtl/movalu_fuse.sv
module movalu_fuse #(
  parameter int RW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [16+3*RW-1:0] in_desc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_fused,
  output logic [16+3*RW-1:0] out_first,
  output logic [16+3*RW-1:0] out_second
);
  localparam int DW  = 16 + 3*RW;
  localparam int OPC = 4;
  localparam int DST = 12;
  localparam int S0  = DST + RW;
  localparam int S1  = S0 + RW;
  localparam int S0V = S1 + RW;
  localparam int S1V = S0V + 1;
  localparam int IMM = S0V + 2;
  localparam int MEM = S0V + 3;

  typedef enum logic [2:0] {A_IDLE, A_LOAD, A_PASS, A_FUSE, A_SPILL} act_t;

  function automatic logic can_park(input logic [DW-1:0] d);
    return d[3:0] == 4'd1 && (d[OPC+:8] == 8'h89 || d[OPC+:8] == 8'h8B)
           && d[S0V] && !d[IMM] && !d[MEM];
  endfunction

  function automatic logic can_join(input logic [DW-1:0] mv, input logic [DW-1:0] op);
    logic hit0, hit1;
    hit0 = op[S0V] && (op[S0+:RW] == mv[S0+:RW] || op[S0+:RW] == mv[DST+:RW]);
    hit1 = op[S1V] && (op[S1+:RW] == mv[S0+:RW] || op[S1+:RW] == mv[DST+:RW]);
    return op[3:0] >= 4'd2 && op[3:0] <= 4'd14
           && op[DST+:RW] == mv[DST+:RW]
           && !op[MEM]
           && (hit0 || hit1)
           && !(op[S0V] && op[S1V] && op[S0+:RW] == op[S1+:RW]);
  endfunction

  logic          hold_v;
  logic [DW-1:0] hold_d;
  act_t          act;

  wire slot = !out_valid || out_ready;

  always_comb begin
    act = A_IDLE;
    if (!flush && in_valid) begin
      if (hold_v)
        act = !slot ? A_IDLE : (can_join(hold_d, in_desc) ? A_FUSE : A_SPILL);
      else
        act = can_park(in_desc) ? A_LOAD : (slot ? A_PASS : A_IDLE);
    end
  end

  assign in_ready = act == A_LOAD || act == A_PASS || act == A_FUSE;
  wire   emit     = act == A_PASS || act == A_FUSE || act == A_SPILL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_fused  <= 1'b0;
      out_first  <= '0;
      out_second <= '0;
    end else if (emit) begin
      out_valid  <= 1'b1;
      out_fused  <= act == A_FUSE;
      out_first  <= (act == A_PASS) ? in_desc : hold_d;
      out_second <= (act == A_FUSE) ? in_desc : '0;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (flush) begin
      hold_v <= 1'b0;
    end else if (act == A_LOAD) begin
      hold_v <= 1'b1;
      hold_d <= in_desc;
    end else if (act == A_FUSE || act == A_SPILL) begin
      hold_v <= 1'b0;
    end
  end
endmodule

// File: rtl/movalu_fuse_chk.sv
module movalu_fuse_chk #(
  parameter int RW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_fused,
  input logic [16+3*RW-1:0] out_first,
  input logic [16+3*RW-1:0] out_second,
  input logic              hold_v
);
  localparam int DST = 12;
  localparam int MEM = 12 + 3*RW + 3;

  p_stall_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_first) && $stable(out_second) && $stable(out_fused));

  p_pair_head_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fused |-> out_first[3:0] == 4'd1 && (out_first[11:4] == 8'h89 || out_first[11:4] == 8'h8B));

  p_pair_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fused |-> out_first[DST+:RW] == out_second[DST+:RW]);

  p_pair_nomem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fused |-> !out_second[MEM]);

  p_pair_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fused |-> out_second[3:0] >= 4'd2 && out_second[3:0] <= 4'd14);

  p_lone_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_fused |-> out_second == '0);

  p_flush_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hold_v);

  p_flush_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);
endmodule

bind movalu_fuse movalu_fuse_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_fused(out_fused),
  .out_first(out_first), .out_second(out_second), .hold_v(hold_v)
);

// File: tb/movalu_fuse_tb.sv
module movalu_fuse_tb;
  localparam int RW = 4;
  localparam int DW = 16 + 3*RW;
  localparam int BW = 2*DW + 1;

  typedef struct packed {
    logic [7:0] aop; logic [3:0] ad; logic [3:0] as;
    logic [3:0] bc; logic [3:0] bd; logic [3:0] b0; logic [3:0] b1;
    logic b0v; logic b1v; logic bi; logic bm; logic ex;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{8'h89, 4'd3, 4'd5, 4'd2,  4'd3, 4'd3, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{8'h8B, 4'd3, 4'd5, 4'd12, 4'd3, 4'd3, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'h89, 4'd3, 4'd5, 4'd2,  4'd4, 4'd4, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h89, 4'd3, 4'd5, 4'd2,  4'd3, 4'd3, 4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{8'h89, 4'd3, 4'd5, 4'd6,  4'd3, 4'd7, 4'd8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h89, 4'd3, 4'd5, 4'd4,  4'd3, 4'd5, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h89, 4'd3, 4'd5, 4'd15, 4'd3, 4'd3, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h8B, 4'd1, 4'd2, 4'd11, 4'd1, 4'd1, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'h8B, 4'd1, 4'd2, 4'd14, 4'd1, 4'd2, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'h88, 4'd1, 4'd2, 4'd2,  4'd1, 4'd1, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h89, 4'd0, 4'd9, 4'd9,  4'd0, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'h89, 4'd2, 4'd4, 4'd1,  4'd2, 4'd2, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };
  localparam string TAG [NV] = '{"R2 R5", "R2 R5", "R3", "R4", "R5", "R6", "R2",
                                 "R2", "R5", "R1", "R2", "R7"};

  logic clk = 0, rst_n = 0, flush = 0, in_valid = 0, out_ready = 1;
  logic [DW-1:0] in_desc = '0;
  logic in_ready, out_valid, out_fused;
  logic [DW-1:0] out_first, out_second;
  int checks = 0, fails = 0, cyc = 0, bp_mode = 0;
  bit done = 0;
  logic [BW-1:0] got[$], exq[$];
  logic m_hv = 0;
  logic [DW-1:0] m_hd = '0;

  movalu_fuse #(.RW(RW)) u_dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (bp_mode == 0) out_ready = 1;
    else if (bp_mode == 1) out_ready = ($urandom % 3) != 0;
    else out_ready = 0;
  end

  always @(negedge clk) if (rst_n && out_valid && out_ready) got.push_back({out_fused, out_first, out_second});

  task automatic report;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired (actual cycle %0d, expected end before 150000)", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input logic [3:0] c, input logic [7:0] op, input logic [3:0] d,
      input logic [3:0] s0, input logic [3:0] s1, input logic v0, input logic v1, input logic im, input logic me);
    return {me, im, v1, v0, s1, s0, d, op, c};
  endfunction

  function automatic bit parkable(input logic [DW-1:0] x);
    if (x[3:0] != 1 || x[DW-1] || x[DW-2] || !x[DW-4]) return 0;
    return x[11:4] == 8'h89 || x[11:4] == 8'h8B;
  endfunction

  function automatic bit pairs(input logic [DW-1:0] m, input logic [DW-1:0] a);
    logic [3:0] md = m[15:12], ms = m[19:16], ad = a[15:12], a0 = a[19:16], a1 = a[23:20];
    bit v0 = a[24], v1 = a[25], rd = 0;
    if (a[3:0] < 2 || a[3:0] > 14 || a[27] || ad != md) return 0;
    if (v0 && v1 && a0 == a1) return 0;
    if (v0 && (a0 == ms || a0 == md)) rd = 1;
    if (v1 && (a1 == ms || a1 == md)) rd = 1;
    return rd;
  endfunction

  function automatic void model(input logic [DW-1:0] x);
    if (m_hv) begin
      m_hv = 0;
      if (pairs(m_hd, x)) begin exq.push_back({1'b1, m_hd, x}); return; end
      exq.push_back({1'b0, m_hd, {DW{1'b0}}});
    end
    if (parkable(x)) begin m_hv = 1; m_hd = x; end
    else exq.push_back({1'b0, x, {DW{1'b0}}});
  endfunction

  task automatic send(input logic [DW-1:0] x);
    @(posedge clk); #2;
    in_valid = 1; in_desc = x;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 0;
    model(x);
  endtask

  task automatic do_flush;
    @(posedge clk); #2 flush = 1;
    @(posedge clk); #2 flush = 0;
    m_hv = 0;
  endtask

  task automatic settle(input string req);
    bp_mode = 0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(got.size() == exq.size(), {req, " beat count"}, got.size(), exq.size());
    for (int i = 0; i < exq.size() && i < got.size(); i++)
      chk(got[i] == exq[i], {req, " beat content"}, got[i][63:0], exq[i][63:0]);
    got.delete(); exq.delete();
  endtask

  localparam logic [DW-1:0] DRAIN = {{(DW-4){1'b0}}, 4'd0};

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R11 out_valid after reset", out_valid, 0);
    chk(in_ready == 0, "R11 in_ready idle after reset", in_ready, 0);

    for (int i = 0; i < NV; i++) begin
      send(mk(4'd1, TBL[i].aop, TBL[i].ad, TBL[i].as, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0));
      send(mk(TBL[i].bc, 8'h01, TBL[i].bd, TBL[i].b0, TBL[i].b1, TBL[i].b0v, TBL[i].b1v, TBL[i].bi, TBL[i].bm));
      send(DRAIN);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(got.size() > 0 && got[0][BW-1] == TBL[i].ex, {TAG[i], " R8 fused flag"},
          got.size() > 0 ? 64'(got[0][BW-1]) : 64'hx, TBL[i].ex);
      settle(TAG[i]);
    end

    send(mk(4'd2, 8'h01, 4'd3, 4'd3, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0));
    send(mk(4'd1, 8'h89, 4'd3, 4'd5, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    send(DRAIN);
    settle("R7 alu before move");

    send(mk(4'd1, 8'h89, 4'd6, 4'd7, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0 && got.size() == 0, "R1 parked move stays", out_valid, 0);
    send(DRAIN);
    settle("R1 parked move release");

    send(mk(4'd1, 8'h8B, 4'd6, 4'd7, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    do_flush();
    send(mk(4'd2, 8'h01, 4'd6, 4'd6, 4'd7, 1'b1, 1'b1, 1'b0, 1'b0));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(got.size() == 1 && got[0][BW-1] == 0 && got[0][DW+3:DW] == 4'd2, "R9 flush drops move",
        got.size(), 1);
    settle("R9 flush");

    bp_mode = 2;
    send(mk(4'd6, 8'h01, 4'd1, 4'd1, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0));
    @(posedge clk); #2;
    in_valid = 1; in_desc = mk(4'd7, 8'h01, 4'd2, 4'd2, 4'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 0, "R10 input stalled", in_ready, 0);
    chk(out_valid == 1 && out_first[3:0] == 4'd6, "R10 output held", out_first[3:0], 6);
    bp_mode = 0;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2 in_valid = 0;
    model(mk(4'd7, 8'h01, 4'd2, 4'd2, 4'd3, 1'b1, 1'b1, 1'b0, 1'b0));
    settle("R10 stall order");

    for (int n = 0; n < 600; n++) begin
      logic [3:0] c;
      logic [7:0] op;
      bp_mode = 1;
      c = ($urandom % 3 == 0) ? 4'd1 : 4'($urandom % 16);
      op = (c == 1) ? (($urandom % 4 == 0) ? 8'h88 : (($urandom % 2) ? 8'h89 : 8'h8B)) : 8'($urandom);
      if (n % 97 == 96) do_flush();
      send(mk(c, op, 4'($urandom % 4), 4'($urandom % 4), 4'($urandom % 4), 1'($urandom),
              1'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 8 == 0)));
    end
    send(DRAIN);
    settle("R10 R7 random stream");

    report();
  end
endmodule